// File: doc/BRIEF.md
# Watchdog Countdown Timer with Software Reload

This block is a coarse-grained system watchdog. Software programs a start count into a byte-wide register and then refreshes the watchdog by writing to a separate reload location. Each refresh copies the stored start count into a down-counter. The counter then steps down by one on every cycle where an external tick-enable is high. That tick-enable comes from a slow prescaler, typically with a period of a fraction of a second.

When the count reaches zero, a sticky expiry flag is raised and driven on the `timeout` pin. The counter then rests at zero until the next refresh. Start counts below four are rejected, so the shortest programmable interval is four ticks. Software reads the flag through a status location and clears it by writing a one.

Register access uses a plain strobe interface with a 2-bit address, separate write and read enables, and one data byte in each direction. Read data is combinational and valid while `rd_en` is high.

Top module: `wdt_timer`

## Requirements
- R1: After synchronous reset the start-count register (address 0) reads 04h, the status register (address 2) reads 00h, the live count (address 3) reads 04h and `timeout` is low.
- R2: In the start-count register only bits 5:0 are storage. Bits 7:6 always read 0, and the values written to them have no effect.
- R3: A write to address 1 (any data) loads the stored start count into the down-counter on that clock edge.
- R4: A write to address 0 whose bits 5:0 hold a value from 0 to 3 is ignored, and the register keeps its previous value. Values 4 to 63 are stored.
- R5: The counter decrements by exactly one on each edge where `tick` is high, and keeps its value on edges where `tick` is low.
- R6: On the edge where the count goes from 1 to 0, the expiry flag (status bit 0) and the `timeout` pin become 1. With a start count of N, this happens on the N-th tick after the reload.
- R7: Once at zero, the counter stays at zero under further ticks until a reload.
- R8: A reload on the same edge as a tick loads the start count; no decrement happens on that edge.
- R9: Writing status with bit 0 = 1 clears the expiry flag. Writing it with bit 0 = 0 leaves the flag unchanged.
- R10: The expiry flag is sticky. A reload does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select: 0 start count, 1 reload, 2 status, 3 live count |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Read data byte, 0 when `rd_en` is low |
| tick | input | 1 | Single-cycle countdown enable from a prescaler |
| timeout | output | 1 | Sticky expiry flag |

## Verification
The bench targets the smallest legal start count of four, which must expire on exactly the fourth tick. A design that accepted values below four, or that counted one tick too many or too few, would raise `timeout` on the wrong cycle. Rejected writes of 1 and 3, including one with the reserved bits set, must leave the previously stored value readable; a design that masked badly would overwrite it or echo the reserved bits. Reload and tick are driven together on one edge, where a design with the wrong priority would read back one less than the start count. Zero-bit status writes and reloads after expiry must leave the flag set, and ticks after expiry must not wrap the counter to 63.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int REG_ADDR_W = 2;

    typedef enum logic [REG_ADDR_W-1:0] {
        SEL_START  = 2'd0,
        SEL_RELOAD = 2'd1,
        SEL_STATUS = 2'd2,
        SEL_COUNT  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_DEC  = 2'd2
    } cnt_op_e;

    typedef struct packed {
        logic wr_start;
        logic wr_reload;
        logic clr_flag;
    } strobes_t;

    function automatic logic start_value_ok(input int unsigned value, input int unsigned floor);
        return value >= floor;
    endfunction

endpackage

// File: rtl/wdt_decode.sv
module wdt_decode import wdt_pkg::*; #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 6
) (
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [CNT_W-1:0]      start_val,
    input  logic [CNT_W-1:0]      count,
    input  logic                  flag,
    output strobes_t              strobes,
    output logic [CNT_W-1:0]      start_cand,
    output logic [DATA_W-1:0]     rd_data
);
    reg_sel_e sel;
    logic     unused_rsvd;

    assign sel         = reg_sel_e'(bus_addr);
    assign start_cand  = wr_data[CNT_W-1:0];
    assign unused_rsvd = ^wr_data[DATA_W-1:CNT_W];

    always_comb begin
        strobes           = '0;
        strobes.wr_start  = wr_en && (sel == SEL_START);
        strobes.wr_reload = wr_en && (sel == SEL_RELOAD);
        strobes.clr_flag  = wr_en && (sel == SEL_STATUS) && wr_data[0];
    end

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            unique case (sel)
                SEL_START:  rd_data = DATA_W'(start_val);
                SEL_RELOAD: rd_data = '0;
                SEL_STATUS: rd_data = DATA_W'(flag);
                SEL_COUNT:  rd_data = DATA_W'(count);
                default:    rd_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/wdt_start_reg.sv
module wdt_start_reg import wdt_pkg::*; #(
    parameter int CNT_W      = 6,
    parameter int MIN_START  = 4,
    parameter int RESET_START = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [CNT_W-1:0] cand,
    output logic [CNT_W-1:0] start_val
);
    logic accept;

    assign accept = wr && start_value_ok(int'(cand), MIN_START);

    always_ff @(posedge clk) begin
        if (rst)
            start_val <= CNT_W'(RESET_START);
        else if (accept)
            start_val <= cand;
    end

    assert_start_floor_R4: assert property (@(posedge clk) disable iff (rst)
        int'(start_val) >= MIN_START);

    assert_reject_low_R4: assert property (@(posedge clk) disable iff (rst)
        (wr && int'(cand) < MIN_START) |=> $stable(start_val));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter import wdt_pkg::*; #(
    parameter int CNT_W       = 6,
    parameter int RESET_START = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reload,
    input  logic             tick,
    input  logic [CNT_W-1:0] start_val,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    cnt_op_e op;

    always_comb begin
        if (reload)
            op = OP_LOAD;
        else if (tick && count != '0)
            op = OP_DEC;
        else
            op = OP_HOLD;
    end

    assign expire = (op == OP_DEC) && (count == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst)
            count <= CNT_W'(RESET_START);
        else begin
            unique case (op)
                OP_LOAD: count <= start_val;
                OP_DEC:  count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assert_load_R3: assert property (@(posedge clk) disable iff (rst)
        reload |=> count == $past(start_val));

    assert_step_R5: assert property (@(posedge clk) disable iff (rst)
        (!reload && tick && count != '0) |=> count == $past(count) - 1'b1);

    assert_idle_R5: assert property (@(posedge clk) disable iff (rst)
        (!reload && !tick) |=> $stable(count));

    assert_zero_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!reload && count == '0) |=> count == '0);
endmodule

// File: rtl/wdt_status.sv
module wdt_status (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (set)
            flag <= 1'b1;
        else if (clr)
            flag <= 1'b0;
    end

    assert_set_R6: assert property (@(posedge clk) disable iff (rst)
        set |=> flag);

    assert_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> flag);

    assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (clr && !set) |=> !flag);
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer import wdt_pkg::*; #(
    parameter int DATA_W      = 8,
    parameter int CNT_W       = 6,
    parameter int MIN_START   = 4,
    parameter int RESET_START = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [DATA_W-1:0]     wr_data,
    output logic [DATA_W-1:0]     rd_data,
    input  logic                  tick,
    output logic                  timeout
);
    strobes_t         strobes;
    logic [CNT_W-1:0] start_cand;
    logic [CNT_W-1:0] start_val;
    logic [CNT_W-1:0] count;
    logic             expire;
    logic             flag;

    wdt_decode #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_decode (
        .bus_addr   (bus_addr),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .wr_data    (wr_data),
        .start_val  (start_val),
        .count      (count),
        .flag       (flag),
        .strobes    (strobes),
        .start_cand (start_cand),
        .rd_data    (rd_data)
    );

    wdt_start_reg #(.CNT_W(CNT_W), .MIN_START(MIN_START), .RESET_START(RESET_START)) u_start (
        .clk       (clk),
        .rst       (rst),
        .wr        (strobes.wr_start),
        .cand      (start_cand),
        .start_val (start_val)
    );

    wdt_counter #(.CNT_W(CNT_W), .RESET_START(RESET_START)) u_counter (
        .clk       (clk),
        .rst       (rst),
        .reload    (strobes.wr_reload),
        .tick      (tick),
        .start_val (start_val),
        .count     (count),
        .expire    (expire)
    );

    wdt_status u_status (
        .clk  (clk),
        .rst  (rst),
        .set  (expire),
        .clr  (strobes.clr_flag),
        .flag (flag)
    );

    assign timeout = flag;

    assert_expire_pin_R6: assert property (@(posedge clk) disable iff (rst)
        (count == CNT_W'(1) && tick && !strobes.wr_reload) |=> (timeout && count == '0));
endmodule

// File: tb/wdt_timer_tb_top.sv
module wdt_timer_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_addr = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       tick = 1'b0;
    logic       timeout;
    logic       pin_chk = 1'b0;
    bit         done = 1'b0;

    int errors = 0;
    int checks = 0;

    typedef struct {
        bit         is_pin;
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    wdt_timer dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .wr_en(wr_en), .rd_en(rd_en),
        .wr_data(wr_data), .rd_data(rd_data), .tick(tick), .timeout(timeout)
    );

    // Monitor: compares outputs away from the active edge
    always @(negedge clk) begin
        if (rd_en || pin_chk) begin
            if (exp_q.size() == 0) begin
                errors++;
                checks++;
                $display("FAIL scoreboard: observation with no expected item");
            end else begin
                item_t it;
                logic [7:0] act;
                it = exp_q.pop_front();
                act = it.is_pin ? {7'd0, timeout} : rd_data;
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual=%02h expected=%02h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
        item_t it;
        it.is_pin = 1'b0; it.exp = e; it.tag = tag;
        exp_q.push_back(it);
        bus_addr = a; rd_en = 1'b1;
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic pin(input logic e, input string tag);
        item_t it;
        it.is_pin = 1'b1; it.exp = {7'd0, e}; it.tag = tag;
        exp_q.push_back(it);
        pin_chk = 1'b1;
        @(posedge clk); #1;
        pin_chk = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic with_tick);
        bus_addr = a; wr_data = d; wr_en = 1'b1; tick = with_tick;
        @(posedge clk); #1;
        wr_en = 1'b0; tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(posedge clk); #1;
            tick = 1'b0;
        end
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        rd(2'd0, 8'h04, "R1 start reg reset");
        rd(2'd2, 8'h00, "R1 status reset");
        rd(2'd3, 8'h04, "R1 count reset");
        pin(1'b0, "R1 timeout reset");

        wr(2'd0, 8'hC7, 1'b0);
        rd(2'd0, 8'h07, "R2 reserved bits read zero");

        wr(2'd0, 8'h03, 1'b0);
        rd(2'd0, 8'h07, "R4 value 3 refused");
        wr(2'd0, 8'hC1, 1'b0);
        rd(2'd0, 8'h07, "R4 value 1 with reserved bits refused");
        wr(2'd0, 8'h0A, 1'b0);
        rd(2'd0, 8'h0A, "R4 value 10 stored");

        wr(2'd1, 8'h00, 1'b0);
        rd(2'd3, 8'h0A, "R3 reload copies start count");

        repeat (3) @(posedge clk);
        #1;
        rd(2'd3, 8'h0A, "R5 no tick no change");
        ticks(3);
        rd(2'd3, 8'h07, "R5 three ticks");

        ticks(6);
        rd(2'd3, 8'h01, "R6 one tick left");
        pin(1'b0, "R6 not yet expired");
        ticks(1);
        rd(2'd3, 8'h00, "R6 count zero");
        pin(1'b1, "R6 timeout raised");
        rd(2'd2, 8'h01, "R6 status flag set");

        ticks(5);
        rd(2'd3, 8'h00, "R7 holds at zero");

        wr(2'd1, 8'h00, 1'b0);
        rd(2'd3, 8'h0A, "R10 reload after expiry");
        rd(2'd2, 8'h01, "R10 flag survives reload");
        pin(1'b1, "R10 pin survives reload");

        wr(2'd2, 8'hFE, 1'b0);
        rd(2'd2, 8'h01, "R9 zero bit leaves flag");
        wr(2'd2, 8'h01, 1'b0);
        rd(2'd2, 8'h00, "R9 one bit clears flag");
        pin(1'b0, "R9 pin cleared");

        ticks(2);
        rd(2'd3, 8'h08, "R8 before collision");
        wr(2'd1, 8'h00, 1'b1);
        rd(2'd3, 8'h0A, "R8 reload wins over tick");

        wr(2'd0, 8'h04, 1'b0);
        rd(2'd0, 8'h04, "R4 floor value stored");
        wr(2'd1, 8'h00, 1'b0);
        ticks(3);
        rd(2'd3, 8'h01, "R6 floor three ticks");
        pin(1'b0, "R6 floor not yet expired");
        ticks(1);
        pin(1'b1, "R6 floor expires on fourth tick");

        @(posedge clk); #1;
        if (exp_q.size() != 0) begin
            errors++;
            checks++;
            $display("FAIL scoreboard: %0d expected items left", exp_q.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule